// File: doc/BRIEF.md
# Multi-Mode 24-Bit Event Counter

This block is the counting core of an event counter. An input decoder ahead of it turns external signals into single-cycle up and down pulses. The core holds a 24-bit count, a 24-bit preset and a 24-bit capture latch. It steps the count in one of three number systems:

- plain binary;
- six-digit BCD;
- a time-of-day format in BCD, with hours in the top byte, minutes in the middle byte and seconds in the bottom byte.

Two options change what happens at the end of the range. Divide-by-N reloads the count from the preset. One-shot mode stops counting after the first wrap.

The core keeps four status flags:

- a carry toggle;
- a borrow toggle;
- a compare toggle;
- a sign flag.

It also drives a pair of output pins whose meaning is chosen by a two-bit field. The surrounding logic supplies single-cycle commands and the configuration word:

| cfg bit | Meaning |
|---|---|
| 0 | BCD |
| 1 | one-shot |
| 2 | divide-by-N |
| 3 | time-of-day |
| 5:4 | pin mode |

The time-of-day bit overrides the BCD bit. The command inputs are master reset, counter clear, load from preset, capture into the latch and compare-toggle clear. A write strobe puts a new preset in place.

All state is registered. A command or count step given in one cycle is visible on the outputs after the next rising edge.

Top module: `evcnt_core`

## Requirements
- R1: After `rst_n` low at a clock edge, or after `cmd_master`, the state is as follows: count is 0, latch is 0, preset is 0xFFFFFF, all three toggles are 0 and `sign_q` is 1.
- R2: In binary mode (cfg[3]=0, cfg[0]=0), an up pulse takes 0xFFFFFF to 0 with a carry, and a down pulse takes 0 to 0xFFFFFF with a borrow.
- R3: In BCD mode (cfg[0]=1, cfg[3]=0), each nibble counts 0 to 9. An up pulse takes 999999 to 000000 with a carry, and a down pulse takes 000000 to 999999 with a borrow.
- R4: In time-of-day mode (cfg[3]=1, whatever cfg[0] is), the bottom and middle bytes count BCD 00..59 and the top byte counts 00..23. An up pulse takes 23:59:59 to 0 with a carry, and a down pulse takes 0 to 23:59:59 with a borrow.
- R5: An up pulse and a down pulse in the same cycle cancel, and the count does not change.
- R6: A carry sets `sign_q` and flips `carry_tgl`. A borrow clears `sign_q` and flips `borrow_tgl`. Outside one-shot mode, each one also raises a carry or borrow pulse for exactly one cycle, in the same cycle that the wrapped count appears.
- R7: With divide-by-N (cfg[2]=1), the count takes the preset value instead of the wrapped value when a carry or borrow occurs.
- R8: In one-shot mode (cfg[1]=1), the toggles and the sign still change on a wrap, but no carry or borrow pulse appears. Later count pulses are ignored until a load, a clear or a master reset.
- R9: `cmp_tgl` flips whenever a count step produces a value equal to the preset. `cmd_cmp_clr` clears it, and the clear wins over a flip in the same cycle.
- R10: `cmd_clear` sets the count to 0, both carry and borrow toggles to 0 and `sign_q` to 1. It leaves `cmp_tgl` and the latch unchanged.
- R11: `cmd_load` copies the preset into the count, and `cmd_latch` copies the count as it was before the edge into the latch. The priority is master, then clear, then load, then count step.
- R12: The pin mode cfg[5:4] selects the pins `{pin_a, pin_b}` as follows:

| cfg[5:4] | `{pin_a, pin_b}` |
|---|---|
| 00 | active-low carry and borrow pulses |
| 01 | carry and borrow toggles |
| 10 | active-high carry and borrow pulses |
| 11 | active-low "count equals preset" and `cmp_tgl` |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, same effect as master reset |
| up_pulse | input | 1 | One-cycle up-count request |
| dn_pulse | input | 1 | One-cycle down-count request |
| cfg | input | 6 | Mode word: bit 0 BCD, bit 1 one-shot, bit 2 divide-by-N, bit 3 time-of-day, bits 5:4 pin mode |
| cmd_master | input | 1 | Master reset command |
| cmd_clear | input | 1 | Counter clear command |
| cmd_load | input | 1 | Preset to count transfer |
| cmd_latch | input | 1 | Count to latch transfer |
| cmd_cmp_clr | input | 1 | Clear compare toggle |
| preset_we | input | 1 | Write strobe for the preset |
| preset_din | input | 24 | New preset value |
| count_q | output | 24 | Current count |
| latch_q | output | 24 | Captured count |
| carry_tgl | output | 1 | Carry toggle flag |
| borrow_tgl | output | 1 | Borrow toggle flag |
| cmp_tgl | output | 1 | Compare toggle flag |
| sign_q | output | 1 | Sign flag |
| pin_a | output | 1 | Programmable output A |
| pin_b | output | 1 | Programmable output B |

## Verification
The assertions rely on a few assumptions about the inputs:

- `cfg` holds still across the cycles a property spans.
- The count and preset hold values that are legal digits for the selected number system whenever BCD or time-of-day mode is active.
- The preset is not rewritten in the same cycle as a load whose result a property checks.

The stimulus keeps the first two assumptions in the following way:

- It changes `cfg` only at the start of a segment, right before a clear.
- It writes only presets generated as legal values for the segment's mode, often within a few steps of either end of the range, so that wraps occur.
- It issues a master reset, which leaves the preset at all ones, only in binary segments.

// File: rtl/evcnt_pkg.sv
// Package: evcnt_pkg
// Shared constants and types of the multi-mode event counter. It fixes the
// bit positions of the configuration word and the per-byte wrap limits.
package evcnt_pkg;

    // Bit positions inside the configuration word
    localparam int CFG_BCD  = 0;
    localparam int CFG_ONCE = 1;
    localparam int CFG_DIVN = 2;
    localparam int CFG_TOD  = 3;
    localparam int CFG_PLO  = 4;
    localparam int CFG_PHI  = 5;
    localparam int CFG_W    = 6;

    // Upper limits of one byte for each number system
    localparam logic [7:0] LIM_BIN = 8'hFF;
    localparam logic [7:0] LIM_BCD = 8'h99;
    localparam logic [7:0] LIM_MS  = 8'h59;
    localparam logic [7:0] LIM_HR  = 8'h23;

    // Meaning of the two output pins
    typedef enum logic [1:0] {
        PM_PULSE_LOW  = 2'b00,
        PM_TOGGLES    = 2'b01,
        PM_PULSE_HIGH = 2'b10,
        PM_COMPARE    = 2'b11
    } pin_mode_t;

endpackage

// File: rtl/evcnt_byte_step.sv
// Module: evcnt_byte_step
// Steps one byte of the count by one, up or down, between 0 and a given
// limit. It works either as a plain binary byte or as two BCD digits.
// When the byte wraps, ripple tells the next byte to step as well.
// Assumes: in decimal use the input holds two valid BCD digits not above lim.
module evcnt_byte_step (
    input  logic [7:0] din,
    input  logic       en,
    input  logic       up,
    input  logic       dec,
    input  logic [7:0] lim,
    output logic [7:0] dout,
    output logic       ripple
);

    // Next value and wrap indication for this byte
    always_comb begin
        dout   = din;
        ripple = 1'b0;
        if (en) begin
            if (up) begin
                if (din == lim) begin
                    dout   = 8'h00;
                    ripple = 1'b1;
                end else if (dec && (din[3:0] >= 4'd9)) begin
                    dout = {din[7:4] + 4'd1, 4'h0};
                end else begin
                    dout = din + 8'd1;
                end
            end else begin
                if (din == 8'h00) begin
                    dout   = lim;
                    ripple = 1'b1;
                end else if (dec && (din[3:0] == 4'd0)) begin
                    dout = {din[7:4] - 4'd1, 4'h9};
                end else begin
                    dout = din - 8'd1;
                end
            end
        end
    end

endmodule

// File: rtl/evcnt_next.sv
// Module: evcnt_next
// Computes the count one step up or down in binary, BCD or time-of-day form.
// It chains one byte stepper per byte. wrap is high when the whole count
// wraps, i.e. a carry when counting up or a borrow when counting down.
// Assumes: time-of-day uses the top byte as hours, the others as min/sec.
module evcnt_next
    import evcnt_pkg::*;
#(
    parameter int NBYTES = 3
) (
    input  logic [8*NBYTES-1:0] cur,
    input  logic                up,
    input  logic                bcd,
    input  logic                tod,
    output logic [8*NBYTES-1:0] nxt,
    output logic                wrap
);

    logic [NBYTES:0] chain;
    logic            dec_mode;

    assign chain[0] = 1'b1;
    assign dec_mode = bcd | tod;

    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        logic [7:0] lim;
        // Limit of this byte for the selected number system
        assign lim = tod ? ((g == NBYTES - 1) ? LIM_HR : LIM_MS)
                         : (bcd ? LIM_BCD : LIM_BIN);

        evcnt_byte_step u_step (
            .din    (cur[8*g +: 8]),
            .en     (chain[g]),
            .up     (up),
            .dec    (dec_mode),
            .lim    (lim),
            .dout   (nxt[8*g +: 8]),
            .ripple (chain[g+1])
        );
    end

    assign wrap = chain[NBYTES];

endmodule

// File: rtl/evcnt_pinmux.sv
// Module: evcnt_pinmux
// Chooses what the two output pins show, according to the pin mode field.
// It is purely combinational and works from registered flags.
module evcnt_pinmux
    import evcnt_pkg::*;
(
    input  pin_mode_t mode,
    input  logic      cy_pulse,
    input  logic      bw_pulse,
    input  logic      cy_tgl,
    input  logic      bw_tgl,
    input  logic      cmp_eq,
    input  logic      cmp_tgl,
    output logic      pin_a,
    output logic      pin_b
);

    // Pin pair selection
    always_comb begin
        unique case (mode)
            PM_PULSE_LOW:  begin pin_a = ~cy_pulse; pin_b = ~bw_pulse; end
            PM_TOGGLES:    begin pin_a = cy_tgl;    pin_b = bw_tgl;    end
            PM_PULSE_HIGH: begin pin_a = cy_pulse;  pin_b = bw_pulse;  end
            default:       begin pin_a = ~cmp_eq;   pin_b = cmp_tgl;   end
        endcase
    end

endmodule

// File: rtl/evcnt_core.sv
// Module: evcnt_core
// Multi-mode event counter core. It holds the count, the preset, the
// capture latch, three toggle flags, a sign flag and the run state for
// one-shot mode. Count pulses come already decoded, one cycle each.
// Priority within one cycle: master reset, clear, load, count step.
// Assumes: cfg is stable while counting, and BCD or time-of-day modes
// are used only with count and preset values that are legal for them.
module evcnt_core
    import evcnt_pkg::*;
#(
    parameter int NBYTES = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                up_pulse,
    input  logic                dn_pulse,
    input  logic [5:0]          cfg,
    input  logic                cmd_master,
    input  logic                cmd_clear,
    input  logic                cmd_load,
    input  logic                cmd_latch,
    input  logic                cmd_cmp_clr,
    input  logic                preset_we,
    input  logic [8*NBYTES-1:0] preset_din,
    output logic [8*NBYTES-1:0] count_q,
    output logic [8*NBYTES-1:0] latch_q,
    output logic                carry_tgl,
    output logic                borrow_tgl,
    output logic                cmp_tgl,
    output logic                sign_q,
    output logic                pin_a,
    output logic                pin_b
);

    localparam int W = 8 * NBYTES;

    logic [W-1:0] count_r, latch_r, preset_r;
    logic [W-1:0] stepped, count_d;
    logic         cyt_r, bwt_r, cmt_r, sign_r, run_r, cyp_r, bwp_r;
    logic         wrap, step_en, wrap_up, wrap_dn, hit, kill, once;

    assign kill = ~rst_n | cmd_master;
    assign once = cfg[CFG_ONCE];

    evcnt_next #(.NBYTES(NBYTES)) u_next (
        .cur  (count_r),
        .up   (up_pulse),
        .bcd  (cfg[CFG_BCD]),
        .tod  (cfg[CFG_TOD]),
        .nxt  (stepped),
        .wrap (wrap)
    );

    // Step qualification: one direction only, no command, counter running
    assign step_en = ~cmd_master & ~cmd_clear & ~cmd_load
                   & (up_pulse ^ dn_pulse) & (run_r | ~once);
    assign wrap_up = step_en & wrap & up_pulse;
    assign wrap_dn = step_en & wrap & dn_pulse;
    assign count_d = (wrap & cfg[CFG_DIVN]) ? preset_r : stepped;
    assign hit     = step_en & (count_d == preset_r);

    // Count register
    always_ff @(posedge clk) begin
        if (kill || cmd_clear) count_r <= '0;
        else if (cmd_load)     count_r <= preset_r;
        else if (step_en)      count_r <= count_d;
    end

    // Preset register
    always_ff @(posedge clk) begin
        if (kill)           preset_r <= '1;
        else if (preset_we) preset_r <= preset_din;
    end

    // Capture latch
    always_ff @(posedge clk) begin
        if (kill)           latch_r <= '0;
        else if (cmd_latch) latch_r <= count_r;
    end

    // Carry and borrow toggles
    always_ff @(posedge clk) begin
        if (kill || cmd_clear) begin
            cyt_r <= 1'b0;
            bwt_r <= 1'b0;
        end else begin
            if (wrap_up) cyt_r <= ~cyt_r;
            if (wrap_dn) bwt_r <= ~bwt_r;
        end
    end

    // Sign flag
    always_ff @(posedge clk) begin
        if (kill || cmd_clear) sign_r <= 1'b1;
        else if (wrap_up)      sign_r <= 1'b1;
        else if (wrap_dn)      sign_r <= 1'b0;
    end

    // Compare toggle
    always_ff @(posedge clk) begin
        if (kill || cmd_cmp_clr) cmt_r <= 1'b0;
        else if (hit)            cmt_r <= ~cmt_r;
    end

    // Run state for one-shot operation
    always_ff @(posedge clk) begin
        if (kill || cmd_clear || cmd_load) run_r <= 1'b1;
        else if (step_en && wrap && once)  run_r <= 1'b0;
    end

    // One-cycle carry and borrow pulses, silent in one-shot mode
    always_ff @(posedge clk) begin
        if (kill) begin
            cyp_r <= 1'b0;
            bwp_r <= 1'b0;
        end else begin
            cyp_r <= wrap_up & ~once;
            bwp_r <= wrap_dn & ~once;
        end
    end

    evcnt_pinmux u_pins (
        .mode     (pin_mode_t'(cfg[CFG_PHI:CFG_PLO])),
        .cy_pulse (cyp_r),
        .bw_pulse (bwp_r),
        .cy_tgl   (cyt_r),
        .bw_tgl   (bwt_r),
        .cmp_eq   (count_r == preset_r),
        .cmp_tgl  (cmt_r),
        .pin_a    (pin_a),
        .pin_b    (pin_b)
    );

    assign count_q    = count_r;
    assign latch_q    = latch_r;
    assign carry_tgl  = cyt_r;
    assign borrow_tgl = bwt_r;
    assign cmp_tgl    = cmt_r;
    assign sign_q     = sign_r;

endmodule

// File: rtl/evcnt_core_chk.sv
// Module: evcnt_core_chk
// Checker bound to evcnt_core. It relates commands and steps to the state
// seen after the next clock edge.
// Assumes: cfg stable across each checked pair of cycles.
module evcnt_core_chk #(
    parameter int NBYTES = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                up_pulse,
    input logic                dn_pulse,
    input logic [5:0]          cfg,
    input logic                cmd_master,
    input logic                cmd_clear,
    input logic                cmd_load,
    input logic [8*NBYTES-1:0] count_q,
    input logic [8*NBYTES-1:0] preset_r,
    input logic                carry_tgl,
    input logic                borrow_tgl,
    input logic                cmp_tgl,
    input logic                sign_q,
    input logic                step_en,
    input logic                wrap,
    input logic                cyp_r,
    input logic                bwp_r
);

    AST_MASTER_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_master |=> (count_q == '0) && (preset_r == '1) && sign_q
                       && !carry_tgl && !borrow_tgl && !cmp_tgl); // R1

    AST_CANCEL_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (up_pulse && dn_pulse && !cmd_master && !cmd_clear && !cmd_load)
        |=> $stable(count_q)); // R5

    AST_CARRY_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && wrap && up_pulse)
        |=> (carry_tgl != $past(carry_tgl)) && sign_q); // R6

    AST_BORROW_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && wrap && dn_pulse)
        |=> (borrow_tgl != $past(borrow_tgl)) && !sign_q); // R6

    AST_DIVN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && wrap && cfg[2]) |=> (count_q == $past(preset_r))); // R7

    AST_ONCE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && wrap && cfg[1]) |=> (!cyp_r && !bwp_r)); // R8

    AST_CLEAR_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_clear && !cmd_master)
        |=> (count_q == '0) && !carry_tgl && !borrow_tgl && sign_q); // R10

    AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_load && !cmd_clear && !cmd_master)
        |=> (count_q == $past(preset_r))); // R11

endmodule

bind evcnt_core evcnt_core_chk #(.NBYTES(NBYTES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .up_pulse   (up_pulse),
    .dn_pulse   (dn_pulse),
    .cfg        (cfg),
    .cmd_master (cmd_master),
    .cmd_clear  (cmd_clear),
    .cmd_load   (cmd_load),
    .count_q    (count_q),
    .preset_r   (preset_r),
    .carry_tgl  (carry_tgl),
    .borrow_tgl (borrow_tgl),
    .cmp_tgl    (cmp_tgl),
    .sign_q     (sign_q),
    .step_en    (step_en),
    .wrap       (wrap),
    .cyp_r      (cyp_r),
    .bwp_r      (bwp_r)
);

// File: tb/evcnt_core_tb_top.sv
// Testbench for evcnt_core: directed corner cases followed by seeded random
// segments. Every cycle is compared against a bench-side model whose number
// arithmetic goes through integer seconds or decimal values.
module evcnt_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        up_pulse, dn_pulse;
    logic [5:0]  cfg;
    logic        cmd_master, cmd_clear, cmd_load, cmd_latch, cmd_cmp_clr;
    logic        preset_we;
    logic [23:0] preset_din;
    logic [23:0] count_q, latch_q;
    logic        carry_tgl, borrow_tgl, cmp_tgl, sign_q, pin_a, pin_b;

    always #5 clk = ~clk;

    evcnt_core dut_i (
        .clk (clk), .rst_n (rst_n), .up_pulse (up_pulse), .dn_pulse (dn_pulse),
        .cfg (cfg), .cmd_master (cmd_master), .cmd_clear (cmd_clear),
        .cmd_load (cmd_load), .cmd_latch (cmd_latch), .cmd_cmp_clr (cmd_cmp_clr),
        .preset_we (preset_we), .preset_din (preset_din), .count_q (count_q),
        .latch_q (latch_q), .carry_tgl (carry_tgl), .borrow_tgl (borrow_tgl),
        .cmp_tgl (cmp_tgl), .sign_q (sign_q), .pin_a (pin_a), .pin_b (pin_b)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [23:0] m_cnt, m_lat, m_pre;
    bit m_cyt, m_bwt, m_cmt, m_sign, m_run, m_cyp, m_bwp;

    function automatic int bcd_to_int(input logic [23:0] v);
        int r = 0;
        for (int i = 5; i >= 0; i--) r = r * 10 + int'(v[i*4 +: 4]);
        return r;
    endfunction

    function automatic logic [23:0] int_to_bcd(input int n);
        logic [23:0] r;
        int k = n;
        for (int i = 0; i < 6; i++) begin
            r[i*4 +: 4] = 4'(k % 10);
            k = k / 10;
        end
        return r;
    endfunction

    function automatic logic [7:0] two_dig(input int n);
        return {4'(n / 10), 4'(n % 10)};
    endfunction

    function automatic int tod_to_int(input logic [23:0] v);
        int h, m, s;
        h = int'(v[23:20]) * 10 + int'(v[19:16]);
        m = int'(v[15:12]) * 10 + int'(v[11:8]);
        s = int'(v[7:4]) * 10 + int'(v[3:0]);
        return h * 3600 + m * 60 + s;
    endfunction

    function automatic logic [23:0] int_to_tod(input int n);
        return {two_dig(n / 3600), two_dig((n / 60) % 60), two_dig(n % 60)};
    endfunction

    // Modulus of the number system picked by cfg
    function automatic int modulus(input logic [5:0] c);
        if (c[3]) return 86400;
        if (c[0]) return 1000000;
        return 1 << 24;
    endfunction

    function automatic int to_int(input logic [23:0] v, input logic [5:0] c);
        if (c[3]) return tod_to_int(v);
        if (c[0]) return bcd_to_int(v);
        return int'(v);
    endfunction

    function automatic logic [23:0] from_int(input int n, input logic [5:0] c);
        if (c[3]) return int_to_tod(n);
        if (c[0]) return int_to_bcd(n);
        return 24'(n);
    endfunction

    // Legal value for the mode, often close to either end of the range
    function automatic logic [23:0] pick_val(input logic [5:0] c);
        int md = modulus(c);
        int k  = int'($urandom % 4);
        int r  = int'($urandom % 4);
        if (r == 0) return from_int(k, c);
        if (r == 1) return from_int(md - 1 - k, c);
        return from_int(int'($urandom % 32'(md)), c);
    endfunction

    function automatic logic [1:0] exp_pins();
        case (cfg[5:4])
            2'b00:   return {~m_cyp, ~m_bwp};
            2'b01:   return {m_cyt, m_bwt};
            2'b10:   return {m_cyp, m_bwp};
            default: return {~(m_cnt == m_pre), m_cmt};
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, "count", {8'h0, count_q}, {8'h0, m_cnt});
        chk(req, "latch", {8'h0, latch_q}, {8'h0, m_lat});
        chk(req, "flags", {28'h0, carry_tgl, borrow_tgl, cmp_tgl, sign_q},
                          {28'h0, m_cyt, m_bwt, m_cmt, m_sign});
        chk("R12", "pins", {30'h0, pin_a, pin_b}, {30'h0, exp_pins()});
    endtask

    task automatic model_reset();
        m_cnt = '0; m_lat = '0; m_pre = '1;
        m_cyt = 0; m_bwt = 0; m_cmt = 0; m_sign = 1; m_run = 1;
        m_cyp = 0; m_bwp = 0;
    endtask

    task automatic idle_inputs();
        up_pulse = 0; dn_pulse = 0; cmd_master = 0; cmd_clear = 0;
        cmd_load = 0; cmd_latch = 0; cmd_cmp_clr = 0; preset_we = 0;
        preset_din = '0;
    endtask

    // Advance one clock: update the model from the driven inputs, then check
    task automatic tick(input string req);
        logic [23:0] n_cnt, n_lat, n_pre, nv;
        bit n_cyt, n_bwt, n_cmt, n_sign, n_run, n_cyp, n_bwp, step, wr;
        int md, v;
        n_cnt = m_cnt; n_lat = m_lat; n_pre = m_pre;
        n_cyt = m_cyt; n_bwt = m_bwt; n_cmt = m_cmt; n_sign = m_sign;
        n_run = m_run; n_cyp = 0; n_bwp = 0;
        step = !cmd_master && !cmd_clear && !cmd_load
               && (up_pulse != dn_pulse) && (m_run || !cfg[1]);
        if (cmd_master) begin
            n_cnt = '0; n_lat = '0; n_pre = '1; n_cyt = 0; n_bwt = 0;
            n_cmt = 0; n_sign = 1; n_run = 1;
        end else begin
            if (preset_we) n_pre = preset_din;
            if (cmd_latch) n_lat = m_cnt;
            if (cmd_clear) begin
                n_cnt = '0; n_cyt = 0; n_bwt = 0; n_sign = 1; n_run = 1;
            end else if (cmd_load) begin
                n_cnt = m_pre; n_run = 1;
            end else if (step) begin
                md = modulus(cfg);
                v  = to_int(m_cnt, cfg);
                wr = up_pulse ? (v == md - 1) : (v == 0);
                v  = up_pulse ? (v + 1) % md : (v + md - 1) % md;
                nv = from_int(v, cfg);
                if (wr && cfg[2]) nv = m_pre;
                n_cnt = nv;
                if (wr) begin
                    if (up_pulse) begin n_cyt = !m_cyt; n_sign = 1; n_cyp = !cfg[1]; end
                    else          begin n_bwt = !m_bwt; n_sign = 0; n_bwp = !cfg[1]; end
                    if (cfg[1]) n_run = 0;
                end
                if (nv == m_pre) n_cmt = !m_cmt;
            end
            if (cmd_cmp_clr) n_cmt = 0;
        end
        @(posedge clk);
        #2;
        m_cnt = n_cnt; m_lat = n_lat; m_pre = n_pre; m_cyt = n_cyt;
        m_bwt = n_bwt; m_cmt = n_cmt; m_sign = n_sign; m_run = n_run;
        m_cyp = n_cyp; m_bwp = n_bwp;
        check_all(req);
        idle_inputs();
    endtask

    task automatic set_load(input logic [23:0] v, input string req);
        preset_we = 1; preset_din = v; tick(req);
        cmd_load = 1; tick(req);
    endtask

    task automatic steps(input bit up, input int n, input string req);
        for (int i = 0; i < n; i++) begin
            up_pulse = up; dn_pulse = !up; tick(req);
        end
    endtask

    // Watchdog
    initial begin
        #1_500_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24681));
        idle_inputs();
        cfg = 6'b0; rst_n = 0;
        repeat (3) @(posedge clk);
        #2;
        model_reset();
        rst_n = 1;
        check_all("R1");

        // R2 binary wrap both ways, active-low pulse pins
        set_load(24'hFFFFFE, "R2");
        steps(1, 2, "R2");
        steps(0, 1, "R2");
        cfg = 6'b10_0000;
        steps(0, 1, "R6");
        steps(1, 1, "R6");
        tick("R6");

        // R5 cancel
        up_pulse = 1; dn_pulse = 1; tick("R5");

        // R3 BCD
        cfg = 6'b00_0001; cmd_clear = 1; tick("R10");
        set_load(24'h999998, "R3");
        steps(1, 2, "R3");
        steps(0, 1, "R3");
        set_load(24'h000009, "R3");
        steps(1, 1, "R3");
        steps(0, 2, "R3");

        // R4 time of day, overriding BCD bit
        cfg = 6'b01_1001; cmd_clear = 1; tick("R4");
        set_load(24'h235959, "R4");
        steps(1, 1, "R4");
        steps(0, 1, "R4");
        set_load(24'h005959, "R4");
        steps(1, 1, "R4");
        steps(0, 1, "R4");

        // R7 divide-by-N
        cfg = 6'b10_0100; cmd_clear = 1; tick("R7");
        set_load(24'h000003, "R7");
        steps(0, 9, "R7");

        // R8 one-shot
        cfg = 6'b10_0010; cmd_clear = 1; tick("R8");
        set_load(24'hFFFFFE, "R8");
        steps(1, 4, "R8");
        cmd_load = 1; tick("R8");
        steps(1, 2, "R8");

        // R9 compare toggle and its clear
        cfg = 6'b11_0000; cmd_clear = 1; tick("R9");
        preset_we = 1; preset_din = 24'h000005; tick("R9");
        steps(1, 5, "R9");
        steps(1, 1, "R9");
        steps(0, 1, "R9");
        cmd_cmp_clr = 1; up_pulse = 1; tick("R9");

        // R10 and R11 priority, latch
        cmd_latch = 1; tick("R11");
        cmd_clear = 1; cmd_load = 1; tick("R11");
        cmd_load = 1; up_pulse = 1; tick("R11");
        cmd_latch = 1; cmd_clear = 1; tick("R10");
        cmd_master = 1; cmd_clear = 1; tick("R1");

        // Random segments
        for (int seg = 0; seg < 16; seg++) begin
            logic [31:0] c;
            c = $urandom;
            cfg = {c[5:4], c[3], c[2], (c[9:8] == 2'b00), c[0]};
            cmd_clear = 1; tick("R10");
            set_load(pick_val(cfg), "R11");
            for (int i = 0; i < 250; i++) begin
                int r, q;
                r = int'($urandom % 8);
                q = int'($urandom % 200);
                up_pulse = (r < 3) || (r == 6);
                dn_pulse = (r >= 3 && r < 6) || (r == 6);
                cmd_load    = (q < 4);
                cmd_latch   = (q >= 10 && q < 20);
                cmd_cmp_clr = (q >= 20 && q < 26);
                cmd_clear   = (q == 30);
                cmd_master  = (q == 31) && !cfg[0] && !cfg[3];
                if (q >= 40 && q < 46) begin
                    preset_we = 1; preset_din = pick_val(cfg);
                end
                tick(cfg[3] ? "R4" : (cfg[0] ? "R3" : "R2"));
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule